// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 9-bit words whose producer and consumer run on unrelated clocks. Words enter on the write clock and leave on the read clock. Read and write pointers pass between the two domains as Gray code, through a chain of synchronizer flops. Each side works out its own flags from its local pointer and the synchronized copy of the other pointer.

A static mode input picks one of two read styles. In standard mode a read request pops the oldest word, which appears on the output one read clock later. An empty flag tells the consumer whether a request will be taken. In fall-through mode the oldest word is placed in an output holding register on its own, and an output-ready flag marks it as valid. A read request then acknowledges that word and brings the next one forward. The holding register adds one word of storage, so every threshold moves by one word in this mode.

The block has three active-low threshold flags. The almost-full flag belongs to the write clock and uses a full offset. The almost-empty flag belongs to the read clock and uses an empty offset. The half-full flag is driven by both domains: a write edge sets it and a read edge clears it. Depth and both offsets are parameters. The mode may only change while reset is held.

Top module: `dcfifo_flags`

## Requirements
- R1: While `rst_n` is low and just after it is released, the outputs are: `full`=0, `almost_full_n`=1, `half_full_n`=1, `empty`=1, `word_ready`=0, `almost_empty_n`=0, `rd_data`=0.
- R2: In standard mode (`fwft_mode`=0), words leave in the order they were written. A read request taken on a read-clock edge places the word on `rd_data` at that same edge. `word_ready` stays 0 in this mode.
- R3: In fall-through mode (`fwft_mode`=1), the oldest word appears on `rd_data` with `word_ready`=1 and no read request. While `rd_en` is 0, `rd_data` and `word_ready` hold. A read request acknowledges the word and brings the next one forward. `empty` is the inverse of `word_ready`.
- R4: `almost_full_n` is low when the stored count is at least DEPTH−FULL_OFS in standard mode, or at least DEPTH+1−FULL_OFS in fall-through mode. The stored count in fall-through mode includes the held output word. The flag is updated on write-clock edges.
- R5: `almost_empty_n` is low when the stored count is at most EMPTY_OFS in standard mode, or at most EMPTY_OFS+1 in fall-through mode. The flag is updated on read-clock edges.
- R6: `half_full_n` is low when the memory pointer difference is greater than DEPTH/2. With no reads, it goes low after DEPTH/2+1 writes in standard mode and after DEPTH/2+2 writes in fall-through mode. It returns high once reads bring the difference back to DEPTH/2.
- R7: `full` is high when DEPTH words are stored in standard mode, or DEPTH+1 words in fall-through mode. A write attempted while `full` is high is dropped and the write pointer does not move.
- R8: A read request while `empty` is high in standard mode is ignored: `rd_data` and the read pointer stay unchanged. An acknowledge while `word_ready` is low in fall-through mode is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_mode | input | 1 | 0 = standard read, 1 = fall-through read; change only in reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No room for another word (write domain) |
| almost_full_n | output | 1 | Active-low almost-full threshold flag (write domain) |
| rd_en | input | 1 | Read request (standard) or acknowledge (fall-through) |
| rd_data | output | DATA_W | Output word register |
| empty | output | 1 | Nothing available to read (read domain) |
| word_ready | output | 1 | Fall-through output word is valid |
| almost_empty_n | output | 1 | Active-low almost-empty threshold flag (read domain) |
| half_full_n | output | 1 | Active-low half-full flag, set by writes and cleared by reads |

## Verification
The bound checker watches several rules on every clock edge. Dropped writes at full must leave the write pointer in place. Requests at empty in standard mode must leave the read pointer and the output word unchanged. A fall-through word must hold while it is not acknowledged. Full must always come with almost-full, and standard-mode empty with almost-empty. The exact thresholds of each flag in both modes only show up in the bench's directed scenarios. These include the one-word shift from the holding register, the half-full flag being set by one clock and cleared by the other, and end-to-end data order. The bench checks every flag against the stored count after each single write or read, once the synchronizers have settled.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Binary to Gray conversion on a 32-bit container.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary conversion on a 32-bit container.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
    parameter int DEPTH       = 512,
    parameter int ADDR_W      = $clog2(DEPTH),
    parameter int FULL_OFS    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_gray_async,
    output logic [ADDR_W:0]   wr_bin,
    output logic [ADDR_W:0]   wr_gray,
    output logic              mem_we,
    output logic              full,
    output logic              almost_full_n
);
    import dcf_pkg::*;
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] AF_THR  = PTR_W'(DEPTH - FULL_OFS);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             full;
        logic             afull_n;
    } wr_state_t;

    wr_state_t        st_d, st_q;
    logic [PTR_W-1:0] rd_gray_s, rd_bin_s, occ;
    logic             accept;

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rsync (
        .clk(wr_clk), .rst_n(rst_n), .d(rd_gray_async), .q(rd_gray_s)
    );

    always_comb begin
        rd_bin_s     = PTR_W'(from_gray(32'(rd_gray_s)));
        accept       = wr_en && !st_q.full;
        st_d         = st_q;
        st_d.bin     = st_q.bin + PTR_W'(accept);
        st_d.gray    = PTR_W'(to_gray(32'(st_d.bin)));
        occ          = st_d.bin - rd_bin_s;
        st_d.full    = (occ == DEPTH_P);
        st_d.afull_n = !(occ >= AF_THR);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, full: 1'b0, afull_n: 1'b1};
        else        st_q <= st_d;
    end

    assign wr_bin        = st_q.bin;
    assign wr_gray       = st_q.gray;
    assign mem_we        = accept;
    assign full          = st_q.full;
    assign almost_full_n = st_q.afull_n;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
    parameter int DATA_W      = 9,
    parameter int DEPTH       = 512,
    parameter int ADDR_W      = $clog2(DEPTH),
    parameter int EMPTY_OFS   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              fwft_mode,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_gray_async,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W:0]   rd_bin,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              word_ready,
    output logic              almost_empty_n
);
    import dcf_pkg::*;
    localparam int PTR_W = ADDR_W + 1;
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic              ram_empty;
        logic              valid;
        logic [DATA_W-1:0] dout;
        logic              aempty_n;
    } rd_state_t;

    rd_state_t        st_d, st_q;
    logic [PTR_W-1:0] wr_gray_s, wr_bin_s, occ;
    logic [CNT_W-1:0] total, thr;
    logic             take;

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
        .clk(rd_clk), .rst_n(rst_n), .d(wr_gray_async), .q(wr_gray_s)
    );

    always_comb begin
        wr_bin_s = PTR_W'(from_gray(32'(wr_gray_s)));
        st_d     = st_q;
        take     = 1'b0;
        if (fwft_mode) begin
            // holding register refills whenever it is free or being acknowledged
            take = !st_q.ram_empty && (!st_q.valid || rd_en);
            if (take) begin
                st_d.dout  = mem_rdata;
                st_d.valid = 1'b1;
            end else if (rd_en) begin
                st_d.valid = 1'b0;
            end
        end else begin
            take       = rd_en && !st_q.ram_empty;
            st_d.valid = 1'b0;
            if (take) st_d.dout = mem_rdata;
        end
        st_d.bin       = st_q.bin + PTR_W'(take);
        st_d.gray      = PTR_W'(to_gray(32'(st_d.bin)));
        occ            = wr_bin_s - st_d.bin;
        st_d.ram_empty = (occ == '0);
        total          = CNT_W'(occ) + CNT_W'(fwft_mode && st_d.valid);
        thr            = CNT_W'(EMPTY_OFS) + CNT_W'(fwft_mode);
        st_d.aempty_n  = !(total <= thr);
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, ram_empty: 1'b1, valid: 1'b0,
                              dout: '0, aempty_n: 1'b0};
        else        st_q <= st_d;
    end

    assign rd_bin         = st_q.bin;
    assign rd_gray        = st_q.gray;
    assign rd_data        = st_q.dout;
    assign empty          = fwft_mode ? !st_q.valid : st_q.ram_empty;
    assign word_ready     = fwft_mode && st_q.valid;
    assign almost_empty_n = st_q.aempty_n;
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
    parameter int DATA_W      = 9,
    parameter int DEPTH       = 512,
    parameter int FULL_OFS    = 64,
    parameter int EMPTY_OFS   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              fwft_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              word_ready,
    output logic              almost_empty_n,
    output logic              half_full_n
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam logic [PTR_W-1:0] HALF = PTR_W'(DEPTH / 2);

    logic [PTR_W-1:0]  wr_bin, wr_gray, rd_bin, rd_gray, ptr_diff;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    dcf_wr_side #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .FULL_OFS(FULL_OFS),
                  .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_gray_async(rd_gray),
        .wr_bin(wr_bin), .wr_gray(wr_gray), .mem_we(mem_we), .full(full),
        .almost_full_n(almost_full_n)
    );

    dcf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk(wr_clk), .we(mem_we), .waddr(wr_bin[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(rd_bin[ADDR_W-1:0]), .rdata(mem_rdata)
    );

    dcf_rd_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
                  .EMPTY_OFS(EMPTY_OFS), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .rd_en(rd_en),
        .wr_gray_async(wr_gray), .mem_rdata(mem_rdata), .rd_bin(rd_bin),
        .rd_gray(rd_gray), .rd_data(rd_data), .empty(empty),
        .word_ready(word_ready), .almost_empty_n(almost_empty_n)
    );

    // Driven from registers of both domains: a write edge sets it, a read edge clears it.
    assign ptr_diff    = wr_bin - rd_bin;
    assign half_full_n = !(ptr_diff > HALF);
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
    parameter int DATA_W = 9,
    parameter int PTR_W  = 10
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              fwft_mode,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full,
    input logic              almost_full_n,
    input logic              empty,
    input logic              word_ready,
    input logic              almost_empty_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  wr_bin,
    input logic [PTR_W-1:0]  rd_bin
);
    // R7
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wr_bin));

    // R7
    full_has_afull_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> !almost_full_n);

    // R8
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft_mode && empty && rd_en) |=> ($stable(rd_bin) && $stable(rd_data)));

    // R3
    fwft_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fwft_mode && word_ready && !rd_en) |=> (word_ready && $stable(rd_data)));

    // R5
    empty_has_aempty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft_mode && empty) |-> !almost_empty_n);

    // R2
    std_no_ready_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !fwft_mode |-> !word_ready);
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) chk_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .rd_en(rd_en), .full(full), .almost_full_n(almost_full_n),
    .empty(empty), .word_ready(word_ready), .almost_empty_n(almost_empty_n),
    .rd_data(rd_data), .wr_bin(wr_bin), .rd_bin(rd_bin)
);

// File: tb/dcfifo_flags_tb_top.sv
module dcfifo_flags_tb_top;
    localparam int DW = 9;
    localparam int D  = 16;
    localparam int M  = 3;
    localparam int N  = 2;

    logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic          fwft_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          full, almost_full_n, empty, word_ready, almost_empty_n, half_full_n;
    logic [DW-1:0] rd_data;
    int total = 0, bad = 0;

    always #2 wr_clk = ~wr_clk;   // 250 MHz write clock
    always #3 rd_clk = ~rd_clk;   // slower, unrelated read clock

    dcfifo_flags #(.DATA_W(DW), .DEPTH(D), .FULL_OFS(M), .EMPTY_OFS(N)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
        .wr_en(wr_en), .wr_data(wr_data), .full(full), .almost_full_n(almost_full_n),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .word_ready(word_ready),
        .almost_empty_n(almost_empty_n), .half_full_n(half_full_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; fwft_mode = mode;
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
    endtask

    task automatic settle();
        repeat (10) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = v;
        @(negedge wr_clk); wr_en = 1'b0;
    endtask

    // one read-clock request; in standard mode the word is on rd_data at the next negedge
    task automatic pulse_rd();
        @(negedge rd_clk); rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int seed, input int k);
        return DW'((k * 37 + seed * 11 + 5) % 512);
    endfunction

    // Expected flags for c stored words, taken from the requirement thresholds.
    task automatic check_flags(input int c, input logic fw);
        int ram = fw ? ((c > 0) ? c - 1 : 0) : c;
        chk("R4", $sformatf("almost_full_n at count %0d", c), almost_full_n,
            int'(!(c >= (fw ? D + 1 - M : D - M))));
        chk("R5", $sformatf("almost_empty_n at count %0d", c), almost_empty_n,
            int'(!(c <= (fw ? N + 1 : N))));
        chk("R6", $sformatf("half_full_n at count %0d", c), half_full_n, int'(!(ram > D / 2)));
        chk("R7", $sformatf("full at count %0d", c), full, int'(c == (fw ? D + 1 : D)));
        chk(fw ? "R3" : "R2", $sformatf("empty at count %0d", c), empty, int'(c == 0));
        chk(fw ? "R3" : "R2", $sformatf("word_ready at count %0d", c), word_ready,
            int'(fw && c > 0));
    endtask

    task automatic test_r1_reset();
        @(negedge wr_clk); rst_n = 1'b0;
        repeat (2) @(negedge rd_clk);
        chk("R1", "full in reset", full, 0);
        chk("R1", "almost_full_n in reset", almost_full_n, 1);
        chk("R1", "half_full_n in reset", half_full_n, 1);
        chk("R1", "empty in reset", empty, 1);
        chk("R1", "word_ready in reset", word_ready, 0);
        chk("R1", "almost_empty_n in reset", almost_empty_n, 0);
        chk("R1", "rd_data in reset", rd_data, 0);
        do_reset(1'b0);
        settle();
        chk("R1", "empty after release", empty, 1);
        chk("R1", "almost_full_n after release", almost_full_n, 1);
    endtask

    task automatic test_std_fill_drain();
        do_reset(1'b0);
        settle();
        check_flags(0, 1'b0);
        for (int k = 1; k <= D; k++) begin
            push(pat(1, k));
            settle();
            check_flags(k, 1'b0);
        end
        push(9'h1FF);                       // R7 dropped while full
        settle();
        check_flags(D, 1'b0);
        for (int r = 1; r <= D; r++) begin
            pulse_rd();
            chk("R2", $sformatf("std word %0d", r), rd_data, pat(1, r));
            settle();
            check_flags(D - r, 1'b0);
        end
    endtask

    task automatic test_r8_std_empty_read();
        logic [DW-1:0] held;
        do_reset(1'b0);
        settle();
        push(9'h0C3);
        settle();
        pulse_rd();
        held = rd_data;
        pulse_rd();                          // request while empty
        settle();
        chk("R8", "rd_data after read at empty", rd_data, held);
        chk("R8", "empty after read at empty", empty, 1);
        push(9'h1A5);
        settle();
        pulse_rd();
        chk("R8", "next word after ignored read", rd_data, 9'h1A5);
    endtask

    task automatic test_fwft();
        do_reset(1'b1);
        settle();
        check_flags(0, 1'b1);
        pulse_rd();                          // R8 acknowledge while not ready
        settle();
        for (int k = 1; k <= D + 1; k++) begin
            push(pat(2, k));
            settle();
            check_flags(k, 1'b1);
            if (k == 1) chk("R3", "first word shown without request", rd_data, pat(2, 1));
        end
        push(9'h1FF);                       // R7 dropped while full
        settle();
        check_flags(D + 1, 1'b1);
        for (int r = 1; r <= D + 1; r++) begin
            @(negedge rd_clk);
            chk("R3", $sformatf("fall-through word %0d", r), rd_data, pat(2, r));
            pulse_rd();
            settle();
            check_flags(D + 1 - r, 1'b1);
        end
        pulse_rd();                          // R8 acknowledge while not ready
        push(9'h05A);
        settle();
        chk("R8", "fall-through word after ignored ack", rd_data, 9'h05A);
        chk("R3", "word_ready after refill", word_ready, 1);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_r1_reset();
        test_std_fill_drain();
        test_r8_std_empty_read();
        test_fwft();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule